// File: doc/BRIEF.md
# Routed Level-Sensitive Interrupt Controller

This block gathers 32 level-sensitive interrupt inputs from peripherals and drives eight CPU interrupt lines. A source takes part only while its enable bit is set and its input is high. Every source carries its own 4-bit line selector, so software decides which CPU line each source raises. Several sources may share one line; that line stays high while any of them is pending.

Software sees six 32-bit words through a simple read/write port: an enable word, a read-only level snapshot and four routing words. The routing words run in reverse: the highest routing word holds sources 0 to 7 and the lowest holds sources 24 to 31. The inputs are resynchronised by two flops before they reach the snapshot and the output logic. A handler reads enable AND level and services the lowest set bit first.

Top module: `route_intc`

## Requirements
- R1: After reset the enable word and all four routing words read zero and every CPU line is low.
- R2: The enable word sits at byte offset 0x00 and is read/write. Bit n enables source n.
- R3: Offset 0x04 returns the synchronised raw level of all 32 inputs, whatever the enable bits hold. A write to 0x04 changes no register.
- R4: The routing words sit at offsets 0x08, 0x0C, 0x10 and 0x14 and are read/write. Offset 0x14 holds sources 0-7, 0x10 holds 8-15, 0x0C holds 16-23 and 0x08 holds 24-31. Source s uses bits [(s%8)*4+3:(s%8)*4] of its word.
- R5: CPU line k is high exactly when some source s has its enable bit set, its synchronised level high and its routing field equal to k.
- R6: A routing field of 8 to 15 sends its source to no CPU line.
- R7: The lines are level-driven. A line stays high while any enabled source routed to it stays high, and falls once all of them are low.
- R8: An input change reaches the level snapshot and the CPU lines after two rising clock edges, and not after one.
- R9: Any offset other than the six word offsets, including a misaligned one, reads zero. A write to such an offset changes no register.
- R10: Clearing a source's enable bit removes it from its CPU line right after the write edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 32 | Peripheral interrupt levels, asynchronous |
| wr_en_i | input | 1 | Write strobe for the register port |
| addr_i | input | 8 | Byte offset for reads and writes |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| cpu_irq_o | output | 8 | CPU interrupt lines |

## Verification
A corrupt routing field shows up as a wrong line as soon as its source is enabled and high. The bench would see it at the first pattern that hits that source, or as a wrong routing word on read-back. A bad enable bit or decode slip changes a line or a read word within the same cycle. A synchronizer off by one stage moves a line by a cycle, and the bench catches that by sampling just after the first edge and again after the second.

// File: rtl/intc_pkg.sv
package intc_pkg;
  typedef enum logic [1:0] {
    REG_ENABLE,
    REG_LEVEL,
    REG_ROUTE,
    REG_NONE
  } reg_kind_e;

  localparam int unsigned WORD_ENABLE = 0;
  localparam int unsigned WORD_LEVEL  = 1;
  localparam int unsigned WORD_ROUTE0 = 2;
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;

  // cycles since reset, for the lag check only
  logic [1:0] warm_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) warm_q <= 2'd0;
    else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
  end

  p_two_stage_lag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd2) |-> (q_o == $past(d_i, 2)));
endmodule

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned SEL_W   = 4,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [DATA_W-1:0]        wdata_i,
  input  logic [NUM_SRC-1:0]       level_i,
  output logic [DATA_W-1:0]        rdata_o,
  output logic [NUM_SRC-1:0]       enable_o,
  output logic [NUM_SRC*SEL_W-1:0] route_o
);
  localparam int unsigned SRC_PER_REG = DATA_W / SEL_W;
  localparam int unsigned NUM_ROUTE   = NUM_SRC / SRC_PER_REG;
  localparam int unsigned RIDX_W      = (NUM_ROUTE > 1) ? $clog2(NUM_ROUTE) : 1;
  localparam int unsigned WORD_W      = ADDR_W - 2;

  logic [NUM_SRC-1:0]                enable_q;
  logic [NUM_ROUTE-1:0][DATA_W-1:0]  route_q;
  logic [WORD_W-1:0]                 word_idx;
  logic [RIDX_W-1:0]                 ridx;
  reg_kind_e                         kind;

  assign word_idx = addr_i[ADDR_W-1:2];
  assign ridx     = RIDX_W'(word_idx - WORD_W'(WORD_ROUTE0));

  always_comb begin
    if (addr_i[1:0] != 2'b00)                          kind = REG_NONE;
    else if (word_idx == WORD_W'(WORD_ENABLE))         kind = REG_ENABLE;
    else if (word_idx == WORD_W'(WORD_LEVEL))          kind = REG_LEVEL;
    else if (word_idx >= WORD_W'(WORD_ROUTE0) &&
             word_idx <  WORD_W'(WORD_ROUTE0 + NUM_ROUTE)) kind = REG_ROUTE;
    else                                               kind = REG_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enable_q <= '0;
      route_q  <= '0;
    end else if (wr_en_i) begin
      case (kind)
        REG_ENABLE: enable_q     <= wdata_i[NUM_SRC-1:0];
        REG_ROUTE:  route_q[ridx] <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    case (kind)
      REG_ENABLE: rdata_o[NUM_SRC-1:0] = enable_q;
      REG_LEVEL:  rdata_o[NUM_SRC-1:0] = level_i;
      REG_ROUTE:  rdata_o = route_q[ridx];
      default: ;
    endcase
  end

  assign enable_o = enable_q;

  // reversed bank: last word carries the lowest sources
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_field
    assign route_o[s*SEL_W +: SEL_W] =
      route_q[NUM_ROUTE-1-(s/SRC_PER_REG)][(s%SRC_PER_REG)*SEL_W +: SEL_W];
  end

  p_enable_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(0)) |=> (enable_o == $past(wdata_i[NUM_SRC-1:0])));

  p_level_readonly_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(4)) |=> ($stable(enable_q) && $stable(route_q)));

  p_unmapped_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && kind == REG_NONE) |=> ($stable(enable_q) && $stable(route_q)));
endmodule

// File: rtl/intc_router.sv
module intc_router #(
  parameter int unsigned NUM_SRC  = 32,
  parameter int unsigned NUM_LINE = 8,
  parameter int unsigned SEL_W    = 4
) (
  input  logic [NUM_SRC-1:0]       pending_i,
  input  logic [NUM_SRC*SEL_W-1:0] route_i,
  output logic [NUM_LINE-1:0]      line_o
);
  always_comb begin
    line_o = '0;
    for (int k = 0; k < NUM_LINE; k++) begin
      for (int s = 0; s < NUM_SRC; s++) begin
        if (pending_i[s] && route_i[s*SEL_W +: SEL_W] == SEL_W'(k))
          line_o[k] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/route_intc.sv
module route_intc #(
  parameter int unsigned NUM_SRC  = 32,
  parameter int unsigned NUM_LINE = 8,
  parameter int unsigned SEL_W    = 4,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_SRC-1:0]  irq_i,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic [NUM_LINE-1:0] cpu_irq_o
);
  logic [NUM_SRC-1:0]       level;
  logic [NUM_SRC-1:0]       enable;
  logic [NUM_SRC*SEL_W-1:0] route;
  logic [NUM_SRC-1:0]       pending;

  intc_sync #(.WIDTH(NUM_SRC)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (irq_i),
    .q_o    (level)
  );

  intc_regs #(
    .NUM_SRC (NUM_SRC),
    .SEL_W   (SEL_W),
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W)
  ) i_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .level_i  (level),
    .rdata_o  (rdata_o),
    .enable_o (enable),
    .route_o  (route)
  );

  assign pending = enable & level;

  intc_router #(
    .NUM_SRC  (NUM_SRC),
    .NUM_LINE (NUM_LINE),
    .SEL_W    (SEL_W)
  ) i_router (
    .pending_i (pending),
    .route_i   (route),
    .line_o    (cpu_irq_o)
  );

  p_quiet_no_pending_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending == '0) |-> (cpu_irq_o == '0));

  p_lines_bounded_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(cpu_irq_o) <= $countones(pending));
endmodule

// File: tb/test_route_intc.sv
module test_route_intc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  cpu_irq;

  int n_checks = 0;
  int n_fail   = 0;

  logic [31:0] mask_sh;
  logic [31:0] route_sh [4];

  always #2 clk = ~clk;

  route_intc i_route_intc (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .irq_i     (irq),
    .wr_en_i   (wr_en),
    .addr_i    (addr),
    .wdata_i   (wdata),
    .rdata_o   (rdata),
    .cpu_irq_o (cpu_irq)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a == 8'h00) mask_sh = d;
    else if (a == 8'h08 || a == 8'h0C || a == 8'h10 || a == 8'h14) route_sh[(a - 8'h08) >> 2] = d;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  function automatic logic [7:0] route_off(input int s);
    return 8'h14 - 8'(4 * (s / 8));
  endfunction

  task automatic set_route(input int s, input logic [3:0] line);
    logic [31:0] w;
    w = route_sh[3 - s / 8];
    w[(s % 8) * 4 +: 4] = line;
    wr(route_off(s), w);
  endtask

  task automatic drive_irq(input logic [31:0] v);
    @(negedge clk);
    irq = v;
    @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic [7:0] model();
    logic [7:0] o = '0;
    for (int s = 0; s < 32; s++) begin
      logic [3:0] f = route_sh[3 - s / 8][(s % 8) * 4 +: 4];
      if (mask_sh[s] && irq[s] && f < 4'd8) o[f[2:0]] = 1'b1;
    end
    return o;
  endfunction

  task automatic check_lines(input string tag);
    logic [7:0] e = model();
    check(cpu_irq === e, tag, {24'h0, cpu_irq}, {24'h0, e});
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check(cpu_irq === 8'h00, "R1 lines", {24'h0, cpu_irq}, 32'h0);
    rd(8'h00, d); check(d === 32'h0, "R1 enable", d, 32'h0);
    for (int r = 0; r < 4; r++) begin
      rd(8'h08 + 8'(4 * r), d); check(d === 32'h0, "R1 route", d, 32'h0);
    end
  endtask

  task automatic t_enable_rw();
    logic [31:0] d;
    wr(8'h00, 32'hA5C3_F00F);
    rd(8'h00, d); check(d === 32'hA5C3_F00F, "R2 readback", d, 32'hA5C3_F00F);
    wr(8'h00, 32'h0);
  endtask

  task automatic t_level_view();
    logic [31:0] d;
    drive_irq(32'h8001_4200);
    rd(8'h04, d); check(d === 32'h8001_4200, "R3 level with enable off", d, 32'h8001_4200);
    check(cpu_irq === 8'h00, "R3 lines while disabled", {24'h0, cpu_irq}, 32'h0);
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, d); check(d === 32'h8001_4200, "R3 level after write", d, 32'h8001_4200);
    rd(8'h00, d); check(d === 32'h0, "R3 enable after level write", d, 32'h0);
    rd(8'h14, d); check(d === 32'h0, "R3 route after level write", d, 32'h0);
    drive_irq(32'h0);
  endtask

  task automatic t_layout();
    logic [31:0] d;
    wr(8'h14, 32'h7654_3210);
    wr(8'h08, 32'h5000_0003);
    rd(8'h14, d); check(d === 32'h7654_3210, "R4 word 0x14", d, 32'h7654_3210);
    rd(8'h08, d); check(d === 32'h5000_0003, "R4 word 0x08", d, 32'h5000_0003);
    wr(8'h00, 32'hFFFF_FFFF);
    drive_irq(32'h0000_0008);
    check(cpu_irq === 8'h08, "R4 source 3 on line 3", {24'h0, cpu_irq}, 32'h08);
    drive_irq(32'h8000_0000);
    check(cpu_irq === 8'h20, "R4 source 31 on line 5", {24'h0, cpu_irq}, 32'h20);
    drive_irq(32'h0100_0000);
    check(cpu_irq === 8'h08, "R4 source 24 on line 3", {24'h0, cpu_irq}, 32'h08);
    drive_irq(32'h0);
  endtask

  task automatic t_routing();
    logic [31:0] pats [4] = '{32'h0000_0001, 32'h8000_0000, 32'h0F0F_0000, 32'hFFFF_FFFF};
    for (int s = 0; s < 32; s++) set_route(s, 4'((s * 3) % 8));
    wr(8'h00, 32'hF0F0_FFFF);
    foreach (pats[i]) begin
      drive_irq(pats[i]);
      check_lines("R5 pattern");
    end
    drive_irq(32'h0);
  endtask

  task automatic t_unrouted();
    for (int s = 0; s < 32; s++) set_route(s, 4'd8);
    set_route(5, 4'd9);
    set_route(6, 4'd15);
    set_route(7, 4'd1);
    wr(8'h00, 32'hFFFF_FFFF);
    drive_irq(32'h0000_0060);
    check(cpu_irq === 8'h00, "R6 fields 9 and 15", {24'h0, cpu_irq}, 32'h0);
    drive_irq(32'h0000_00E0);
    check(cpu_irq === 8'h02, "R6 neighbour on line 1", {24'h0, cpu_irq}, 32'h02);
    drive_irq(32'h0);
  endtask

  task automatic t_level_hold();
    set_route(10, 4'd2);
    set_route(20, 4'd2);
    wr(8'h00, 32'h0010_0400);
    drive_irq(32'h0010_0400);
    check(cpu_irq === 8'h04, "R7 both high", {24'h0, cpu_irq}, 32'h04);
    repeat (5) @(negedge clk);
    check(cpu_irq === 8'h04, "R7 held", {24'h0, cpu_irq}, 32'h04);
    drive_irq(32'h0010_0000);
    check(cpu_irq === 8'h04, "R7 one left", {24'h0, cpu_irq}, 32'h04);
    drive_irq(32'h0);
    check(cpu_irq === 8'h00, "R7 all low", {24'h0, cpu_irq}, 32'h0);
  endtask

  task automatic t_lag();
    logic [31:0] d;
    set_route(12, 4'd6);
    wr(8'h00, 32'h0000_1000);
    @(negedge clk);
    irq = 32'h0000_1000;
    @(negedge clk);
    check(cpu_irq === 8'h00, "R8 not after one edge", {24'h0, cpu_irq}, 32'h0);
    addr = 8'h04;
    #1 check(rdata === 32'h0, "R8 level not after one edge", rdata, 32'h0);
    @(negedge clk);
    check(cpu_irq === 8'h40, "R8 after two edges", {24'h0, cpu_irq}, 32'h40);
    rd(8'h04, d); check(d === 32'h0000_1000, "R8 level after two edges", d, 32'h0000_1000);
    drive_irq(32'h0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    logic [31:0] m0 = mask_sh;
    logic [31:0] r3 = route_sh[3];
    logic [7:0] offs [4] = '{8'h18, 8'h40, 8'h05, 8'hFC};
    foreach (offs[i]) begin
      wr(offs[i], 32'hDEAD_BEEF);
      rd(offs[i], d); check(d === 32'h0, "R9 unmapped read", d, 32'h0);
    end
    rd(8'h00, d); check(d === m0, "R9 enable untouched", d, m0);
    rd(8'h14, d); check(d === r3, "R9 route untouched", d, r3);
  endtask

  task automatic t_disable();
    set_route(9, 4'd4);
    wr(8'h00, 32'h0000_0200);
    drive_irq(32'h0000_0200);
    check(cpu_irq === 8'h10, "R10 pending on line 4", {24'h0, cpu_irq}, 32'h10);
    wr(8'h00, 32'h0);
    check(cpu_irq === 8'h00, "R10 cleared after write", {24'h0, cpu_irq}, 32'h0);
    drive_irq(32'h0);
  endtask

  initial begin
    mask_sh = '0;
    foreach (route_sh[i]) route_sh[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_enable_rw();
    t_level_view();
    t_layout();
    t_routing();
    t_unrouted();
    t_level_hold();
    t_lag();
    t_unmapped();
    t_disable();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule